// File: doc/BRIEF.md
# Configuration Image Stream Programmer

This block loads a configuration image into one or more target FPGAs. A host writes the image as 32-bit words into a data window of a small register space. Those words may come from a processor polling the fill level, or from an external DMA engine that answers a request line. The words wait in an on-chip FIFO. A byte serialiser then sends each word out on a byte-wide configuration port, one byte for each configuration clock enable. A byte counter is compared against a total that software loads before it starts.

The stream ends in one of three ways. The target reports done when the last byte has gone, and programming succeeds. The target stays silent, and a short-stream error is flagged. The target raises its error input, and a target error is flagged. Each of these sets a level interrupt. Only a control write that clears the enable bit removes the interrupt, and that same write clears the error flags, the byte counter and the FIFO. A separate control bit holds the targets' active-low configuration reset line low. Software pulses it by writing enable with reset, and then writing zero.

Top module: `cfg_stream_prog`

## Requirements
- R1: After reset, irq, dma_req and cfg_valid are 0, cfg_reset_n is 1, and the status (0x44), used (0x4C) and current count (0x54) registers read 0.
- R2: Register 0x48 reads the FIFO depth in bytes (DEPTH*4, 4096 by default). A write to it has no effect.
- R3: A write to window 0x3000 pushes one word only while control bit 0 (enable) is set. Writes made while disabled are discarded. Register 0x4C returns the number of words waiting in the FIFO, and a control write with bit 0 clear empties the FIFO.
- R4: Each word leaves as four bytes, most significant byte first. A byte goes out on each cfg_tick. cfg_data is valid with cfg_valid in the cycle after the tick, and register 0x54 rises by one for each byte.
- R5: Once register 0x54 equals the total at 0x50, no further byte is emitted, even if words remain in the FIFO.
- R6: A cfg_tick seen while the count equals the total and tgt_done is high ends programming without error and raises irq. Status bit 18 follows tgt_done.
- R7: A cfg_tick seen while the count equals the total and tgt_done is low sets status bit 1 (short stream) and raises irq.
- R8: tgt_err while enabled sets status bit 2, raises irq and stops the byte stream.
- R9: irq stays high until a control write with bit 0 clear. That write drops irq and clears status bits 2:1 and register 0x54.
- R10: cfg_reset_n is low while control bit 1 is set. Writing 3 and then 0 to control gives a reset pulse.
- R11: dma_req is high when control bits 0 and 2 are both set, the stream has not ended, and at least DEPTH/2 FIFO words are free. It is low in processor-fed mode (bit 2 clear).
- R12: A window write to a full FIFO is dropped, and the used count never exceeds DEPTH.
- R13: Status bit 0 reads 1 while the programmer is enabled and the stream has not ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register or window write strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cfg_tick | input | 1 | Configuration clock enable, one byte per tick |
| cfg_data | output | 8 | Configuration byte |
| cfg_valid | output | 1 | cfg_data carries a byte this cycle |
| cfg_reset_n | output | 1 | Active-low configuration reset to the targets |
| tgt_done | input | 1 | Target reports configuration done |
| tgt_err | input | 1 | Target reports a configuration error |
| dma_req | output | 1 | Request for a half-FIFO burst |
| irq | output | 1 | Stream-ended interrupt, level |

## Verification
The assertions assume that software loads the total before it sets enable, and that it does not rewrite the total mid-stream. Under that assumption the emitted count never passes the total. They also assume that the reset bit rises only through a control write. The bench follows this order in every scenario, holds tgt_done and tgt_err low except in the cases that test them, and drives cfg_tick only between bus writes.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int unsigned OFS_CTRL  = 32'h40;
  localparam int unsigned OFS_STAT  = 32'h44;
  localparam int unsigned OFS_SIZE  = 32'h48;
  localparam int unsigned OFS_USED  = 32'h4C;
  localparam int unsigned OFS_TOTAL = 32'h50;
  localparam int unsigned OFS_CUR   = 32'h54;
  localparam int unsigned OFS_WIN   = 32'h3000;

  typedef struct packed {
    logic dma;
    logic rst;
    logic en;
  } ctrl_t;

  function automatic logic [31:0] depth_bytes(int unsigned depth);
    return 32'(depth * 4);
  endfunction

  function automatic logic half_free(logic [31:0] used, int unsigned depth);
    return (32'(depth) - used) >= 32'(depth / 2);
  endfunction

  function automatic logic [31:0] pack_status(logic active, logic short_e,
                                              logic terr, logic done);
    logic [31:0] s;
    s     = '0;
    s[0]  = active;
    s[1]  = short_e;
    s[2]  = terr;
    s[18] = done;
    return s;
  endfunction
endpackage

// File: rtl/cfgp_fifo.sv
module cfgp_fifo #(
  parameter int DEPTH = 1024,
  parameter int W     = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic             head_valid,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign full       = (count == CNT_W'(DEPTH));
  assign head_valid = (count != '0);
  assign head       = mem[rd_ptr];
  assign do_push    = push && !full;
  assign do_pop     = pop && head_valid;

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/cfgp_shifter.sv
module cfgp_shifter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        go,
  input  logic [31:0] head,
  input  logic        head_valid,
  output logic        pop,
  output logic        emit,
  output logic [7:0]  byte_out
);
  logic [31:0] sh_word;
  logic [2:0]  sh_left;
  logic        holding;

  assign holding  = (sh_left != '0);
  assign emit     = go && (holding || head_valid);
  assign pop      = go && !holding && head_valid;
  assign byte_out = holding ? sh_word[31:24] : head[31:24];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_word <= '0;
      sh_left <= '0;
    end else if (clear) begin
      sh_word <= '0;
      sh_left <= '0;
    end else if (pop) begin
      sh_word <= {head[23:0], 8'h00};
      sh_left <= 3'd3;
    end else if (emit) begin
      sh_word <= {sh_word[23:0], 8'h00};
      sh_left <= sh_left - 1'b1;
    end
  end
endmodule

// File: rtl/cfg_stream_prog.sv
module cfg_stream_prog
  import cfgp_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 14,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              cfg_tick,
  output logic [7:0]        cfg_data,
  output logic              cfg_valid,
  output logic              cfg_reset_n,
  input  logic              tgt_done,
  input  logic              tgt_err,
  output logic              dma_req,
  output logic              irq
);
  ctrl_t       ctrl_q;
  logic [31:0] total_q, cur_q;
  logic        fin_q, err_short_q, err_tgt_q, irq_q;
  logic [7:0]  cfg_data_q;
  logic        cfg_valid_q;

  // decoded bus events
  logic ctrl_wr, dis_wr, total_wr, win_wr;
  assign ctrl_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign dis_wr   = ctrl_wr && !bus_wdata[0];
  assign total_wr = bus_wr && (bus_addr == ADDR_W'(OFS_TOTAL));
  assign win_wr   = bus_wr && (bus_addr == ADDR_W'(OFS_WIN));

  // stream events
  logic run, at_end, go, ev_done, ev_short, ev_terr;
  assign run      = ctrl_q.en && !fin_q;
  assign at_end   = (cur_q == total_q);
  assign ev_terr  = run && tgt_err;
  assign ev_done  = run && !tgt_err && cfg_tick && at_end && tgt_done;
  assign ev_short = run && !tgt_err && cfg_tick && at_end && !tgt_done;
  assign go       = run && !tgt_err && cfg_tick && !at_end;

  logic [31:0]      head;
  logic             head_valid, pop, emit, full;
  logic [CNT_W-1:0] fifo_count;
  logic [7:0]       byte_out;
  logic [31:0]      used_w;
  assign used_w = 32'(fifo_count);

  cfgp_fifo #(.DEPTH(DEPTH), .W(32)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(dis_wr),
    .push(win_wr && ctrl_q.en), .wdata(bus_wdata),
    .pop(pop), .head(head), .head_valid(head_valid),
    .count(fifo_count), .full(full)
  );

  cfgp_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .clear(dis_wr), .go(go),
    .head(head), .head_valid(head_valid),
    .pop(pop), .emit(emit), .byte_out(byte_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      total_q     <= '0;
      cur_q       <= '0;
      fin_q       <= 1'b0;
      err_short_q <= 1'b0;
      err_tgt_q   <= 1'b0;
      irq_q       <= 1'b0;
      cfg_data_q  <= '0;
      cfg_valid_q <= 1'b0;
    end else begin
      cfg_valid_q <= emit;
      if (emit) begin
        cfg_data_q <= byte_out;
        cur_q      <= cur_q + 32'd1;
      end
      if (total_wr) total_q <= bus_wdata;
      if (ev_terr) begin
        err_tgt_q <= 1'b1;
        fin_q     <= 1'b1;
        irq_q     <= 1'b1;
      end else if (ev_done) begin
        fin_q <= 1'b1;
        irq_q <= 1'b1;
      end else if (ev_short) begin
        err_short_q <= 1'b1;
        fin_q       <= 1'b1;
        irq_q       <= 1'b1;
      end
      if (ctrl_wr) ctrl_q <= ctrl_t'(bus_wdata[2:0]);
      if (dis_wr) begin
        irq_q       <= 1'b0;
        fin_q       <= 1'b0;
        err_short_q <= 1'b0;
        err_tgt_q   <= 1'b0;
        cur_q       <= '0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (32'(bus_addr))
      OFS_CTRL:  bus_rdata = 32'(ctrl_q);
      OFS_STAT:  bus_rdata = pack_status(run, err_short_q, err_tgt_q, tgt_done);
      OFS_SIZE:  bus_rdata = depth_bytes(DEPTH);
      OFS_USED:  bus_rdata = used_w;
      OFS_TOTAL: bus_rdata = total_q;
      OFS_CUR:   bus_rdata = cur_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign cfg_data    = cfg_data_q;
  assign cfg_valid   = cfg_valid_q;
  assign cfg_reset_n = !ctrl_q.rst;
  assign irq         = irq_q;
  assign dma_req     = run && ctrl_q.dma && half_free(used_w, DEPTH);
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
  parameter int DEPTH = 1024,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             cfg_valid,
  input logic             cfg_reset_n,
  input logic             dma_req,
  input logic             ctrl_wr,
  input logic             dis_wr,
  input logic [31:0]      bus_wdata,
  input logic             ev_done,
  input logic [31:0]      cur_q,
  input logic [31:0]      total_q,
  input logic [CNT_W-1:0] fifo_count,
  input logic [2:0]       ctrl_bits
);
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !dis_wr |=> irq);
  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dis_wr |=> !irq);
  p_done_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> irq);
  p_no_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> cur_q <= total_q);
  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNT_W'(DEPTH));
  p_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dis_wr |=> fifo_count == '0);
  p_reset_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_reset_n) |-> $past(ctrl_wr && bus_wdata[1]));
  p_dma_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> ctrl_bits[2] && ctrl_bits[0]);
endmodule

bind cfg_stream_prog cfgp_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .cfg_valid(cfg_valid),
  .cfg_reset_n(cfg_reset_n), .dma_req(dma_req), .ctrl_wr(ctrl_wr),
  .dis_wr(dis_wr), .bus_wdata(bus_wdata), .ev_done(ev_done),
  .cur_q(cur_q), .total_q(total_q), .fifo_count(fifo_count),
  .ctrl_bits(3'(ctrl_q))
);

// File: tb/tb_cfg_stream_prog.sv
`timescale 1ns/1ps
module tb_cfg_stream_prog;
  localparam int DEPTH  = 1024;
  localparam int ADDR_W = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic cfg_tick = 1'b0, tgt_done = 1'b0, tgt_err = 1'b0;
  logic [7:0] cfg_data;
  logic cfg_valid, cfg_reset_n, dma_req, irq;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cfg_stream_prog #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    bus_addr = ADDR_W'(a);
    #0.5;
    d = bus_rdata;
  endtask

  task automatic tick(output logic v, output logic [7:0] b);
    @(negedge clk);
    cfg_tick = 1'b1;
    @(negedge clk);
    cfg_tick = 1'b0;
    v = cfg_valid; b = cfg_data;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", 32'(irq), 0);
    chk("R1 dma_req", 32'(dma_req), 0);
    chk("R1 cfg_valid", 32'(cfg_valid), 0);
    chk("R1 cfg_reset_n", 32'(cfg_reset_n), 1);
    rd(32'h44, d); chk("R1 status", d, 0);
    rd(32'h4C, d); chk("R1 used", d, 0);
    rd(32'h54, d); chk("R1 cur", d, 0);
    rd(32'h48, d); chk("R2 size", d, 32'(DEPTH * 4));
    wr(32'h48, 32'd5);
    rd(32'h48, d); chk("R2 size after write", d, 32'(DEPTH * 4));
  endtask

  task automatic t_disabled_drop;
    logic [31:0] d;
    wr(32'h3000, 32'h1); wr(32'h3000, 32'h2);
    rd(32'h4C, d); chk("R3 writes while disabled", d, 0);
  endtask

  task automatic t_stream;
    logic [31:0] d; logic v; logic [7:0] b;
    logic [7:0] exp_b [8] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'hA5, 8'hB6, 8'hC7, 8'hD8};
    wr(32'h50, 32'd8);
    wr(32'h40, 32'h1);
    wr(32'h3000, 32'h11223344); wr(32'h3000, 32'hA5B6C7D8);
    rd(32'h4C, d); chk("R3 used", d, 2);
    rd(32'h44, d); chk("R13 active", d, 32'h1);
    for (int i = 0; i < 8; i++) begin
      tick(v, b);
      chk("R4 valid", 32'(v), 1);
      chk("R4 byte order", 32'(b), 32'(exp_b[i]));
    end
    rd(32'h54, d); chk("R4 cur count", d, 8);
    chk("R6 no irq before done tick", 32'(irq), 0);
    tgt_done = 1'b1;
    tick(v, b);
    chk("R6 irq", 32'(irq), 1);
    rd(32'h44, d); chk("R6 status done", d, 32'h40000);
    repeat (3) @(negedge clk);
    chk("R9 irq held", 32'(irq), 1);
    tgt_done = 1'b0;
    wr(32'h40, 32'h0);
    chk("R9 irq cleared", 32'(irq), 0);
    rd(32'h54, d); chk("R9 cur cleared", d, 0);
  endtask

  task automatic t_short;
    logic [31:0] d; logic v; logic [7:0] b;
    wr(32'h50, 32'd4);
    wr(32'h40, 32'h1);
    wr(32'h3000, 32'h01020304); wr(32'h3000, 32'h05060708);
    for (int i = 0; i < 4; i++) begin
      tick(v, b);
      chk("R4 byte", 32'(b), 32'(i + 1));
    end
    tick(v, b);
    chk("R5 no byte past total", 32'(v), 0);
    rd(32'h54, d); chk("R5 cur at total", d, 4);
    rd(32'h4C, d); chk("R5 word left", d, 1);
    rd(32'h44, d); chk("R7 short error", d, 32'h2);
    chk("R7 irq", 32'(irq), 1);
    wr(32'h40, 32'h0);
    rd(32'h44, d); chk("R9 errors cleared", d, 0);
    rd(32'h4C, d); chk("R3 flush", d, 0);
  endtask

  task automatic t_target_err;
    logic [31:0] d; logic v; logic [7:0] b;
    wr(32'h50, 32'd16);
    wr(32'h40, 32'h1);
    wr(32'h3000, 32'hCAFEF00D);
    tick(v, b); chk("R4 byte0", 32'(b), 32'hCA);
    tick(v, b); chk("R4 byte1", 32'(b), 32'hFE);
    @(negedge clk); tgt_err = 1'b1;
    @(negedge clk); tgt_err = 1'b0;
    rd(32'h44, d); chk("R8 target error", d, 32'h4);
    chk("R8 irq", 32'(irq), 1);
    tick(v, b); chk("R8 stream stopped", 32'(v), 0);
    rd(32'h54, d); chk("R8 cur frozen", d, 2);
    wr(32'h40, 32'h0);
  endtask

  task automatic t_reset_pulse;
    wr(32'h40, 32'h3);
    chk("R10 reset low", 32'(cfg_reset_n), 0);
    wr(32'h40, 32'h0);
    chk("R10 reset released", 32'(cfg_reset_n), 1);
  endtask

  task automatic t_dma;
    wr(32'h50, 32'd100);
    wr(32'h40, 32'h5);
    chk("R11 req empty", 32'(dma_req), 1);
    for (int i = 0; i < DEPTH / 2; i++) wr(32'h3000, 32'(i));
    chk("R11 req at half", 32'(dma_req), 1);
    wr(32'h3000, 32'h0);
    chk("R11 req below half free", 32'(dma_req), 0);
    wr(32'h40, 32'h0);
    wr(32'h40, 32'h1);
    chk("R11 no req in cpu mode", 32'(dma_req), 0);
    wr(32'h40, 32'h0);
  endtask

  task automatic t_overflow;
    logic [31:0] d;
    wr(32'h50, 32'd0);
    wr(32'h40, 32'h1);
    for (int i = 0; i < DEPTH + 3; i++) wr(32'h3000, 32'(i));
    rd(32'h4C, d); chk("R12 full", d, 32'(DEPTH));
    wr(32'h40, 32'h0);
    rd(32'h4C, d); chk("R3 flush after full", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled_drop();
    t_stream();
    t_short();
    t_target_err();
    t_reset_pulse();
    t_dma();
    t_overflow();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule